// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits on the CPU side of a host bridge and classifies every access to the lowest megabyte of the address space. Each access carries a 20-bit address, a write flag and the state of the system-management-mode signal. From these the block decides whether the access is claimed by system RAM or forwarded to the PCI side. For the firmware shadow area it also says whether a write must be thrown away. Below 0xA0000 everything is RAM. The 128 KiB graphics window at 0xA0000 to 0xBFFFF opens to RAM only under a control-byte condition, which can be qualified by system management mode. The area from 0xC0000 to 0xFFFFF is cut into thirteen segments, each governed by a two-bit access mode.

The modes and the window control sit in configuration bytes reached through a byte-wide port. The port also presents a read-only byte giving the installed memory in 8 MiB units. The decode is purely combinational from the stored bytes and the access inputs. A configuration write therefore steers accesses from the cycle after its clock edge, and a change of the management-mode input takes effect in the same cycle.

Top module: `legacy_region_decoder`

## Requirements
- R1: After reset every segment mode is 0, so all addresses from 0xC0000 to 0xFFFFF select PCI. The window control byte (offset 0x72) reads 0x02 and the seven mode bytes (offsets 0x59 to 0x5F) read 0x00.
- R2: Any access below 0xA0000 selects RAM (`sel_ram`=1) with `wr_block`=0, whatever the configuration or the mode input.
- R3: The 64 KiB segment 0xF0000 to 0xFFFFF takes its mode from bits 5:4 of offset 0x59.
- R4: The 16 KiB segment number i (0 to 11), starting at 0xC0000 + i*0x4000, takes its mode from offset 0x5A + i/2. It uses bits 1:0 when i is even and bits 5:4 when i is odd.
- R5: Mode encodings: 0 and 2 select PCI, 3 selects RAM for reads and writes, and 1 selects RAM. A write to a mode 1 segment still selects RAM.
- R6: `wr_block` is 1 only for a write to a segment in mode 1. It is 0 for reads, for every other mode, and outside the segment area.
- R7: An access in 0xA0000 to 0xBFFFF selects RAM exactly when (`smm_active` and bit 3 of offset 0x72) or bit 6 of offset 0x72. Otherwise it selects PCI, and `wr_block` is 0.
- R8: Offset 0x57 reads min(floor(`ram_size_mib`/8), 255), and writes to it are ignored.
- R9: A configuration write changes the decode from the cycle after the clock edge that captures it. A change on `smm_active` changes the decode in the same cycle.
- R10: Offsets 0x59 to 0x5F and 0x72 read back the last byte written to them. All other offsets except 0x57 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| ram_size_mib | input | 16 | Installed memory in MiB |
| acc_addr | input | 20 | CPU access address |
| acc_write | input | 1 | 1 for a write access |
| smm_active | input | 1 | System management mode active |
| sel_ram | output | 1 | 1 routes the access to RAM, 0 to PCI |
| wr_block | output | 1 | 1 discards the write data |

## Verification
Some rules are checked by the bound checker on every cycle:
- low memory always routes to RAM;
- the write-discard flag appears only on writes that also route to RAM;
- reads and the graphics window are never write-blocked;
- the window's routing follows a shadow copy of the control byte, rebuilt from port writes, together with the mode input.

The nibble-to-segment mapping, the mode encodings, the size saturation, the readback, the reset values and the one-cycle timing of configuration writes are shown only by the bench. It sweeps mode patterns over all thirteen segments, both segment edges, both access directions and every window control and mode combination.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

  typedef enum logic [1:0] {
    MODE_PCI     = 2'd0,
    MODE_RAM_RO  = 2'd1,
    MODE_PCI_ALT = 2'd2,
    MODE_RAM_RW  = 2'd3
  } seg_mode_e;

  typedef enum logic [1:0] {
    AREA_LOW    = 2'd0,
    AREA_WINDOW = 2'd1,
    AREA_SHADOW = 2'd2
  } area_e;

  localparam int WIN_SMM_BIT   = 3;
  localparam int WIN_FORCE_BIT = 6;

  function automatic logic mode_hits_ram(input logic [1:0] m);
    return (m == MODE_RAM_RO) || (m == MODE_RAM_RW);
  endfunction

  function automatic logic mode_drops_write(input logic [1:0] m, input logic wr);
    return wr && (m == MODE_RAM_RO);
  endfunction

  function automatic logic window_open(input logic [7:0] ctrl, input logic smm);
    return (smm && ctrl[WIN_SMM_BIT]) || ctrl[WIN_FORCE_BIT];
  endfunction

  function automatic logic [7:0] size_units(input logic [31:0] mib);
    logic [31:0] q;
    q = mib >> 3;
    return (q > 32'd255) ? 8'hFF : q[7:0];
  endfunction

endpackage

// File: rtl/lrd_cfg_regs.sv
module lrd_cfg_regs #(
  parameter int          CFG_AW    = 8,
  parameter int          PAM_BYTES = 7,
  parameter logic [7:0]  PAM_BASE  = 8'h59,
  parameter logic [7:0]  WIN_OFF   = 8'h72,
  parameter logic [7:0]  SIZE_OFF  = 8'h57,
  parameter logic [7:0]  WIN_RST   = 8'h02,
  parameter int          MIB_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CFG_AW-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [MIB_W-1:0]       ram_size_mib,
  output logic [PAM_BYTES*8-1:0] pam_flat,
  output logic [7:0]             win_ctrl,
  output logic                   decode_touch
);
  import lrd_pkg::*;

  logic [7:0]           pam_q [PAM_BYTES];
  logic [PAM_BYTES-1:0] pam_sel;
  logic                 win_sel;
  logic                 size_sel;
  logic [7:0]           size_q;

  assign win_sel  = (addr == CFG_AW'(WIN_OFF));
  assign size_sel = (addr == CFG_AW'(SIZE_OFF));
  assign size_q   = size_units({{(32-MIB_W){1'b0}}, ram_size_mib});

  for (genvar k = 0; k < PAM_BYTES; k++) begin : g_pam
    assign pam_sel[k] = (addr == CFG_AW'(int'(PAM_BASE) + k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pam_q[k] <= 8'h00;
      else if (we && pam_sel[k])   pam_q[k] <= wdata;
    end
    assign pam_flat[k*8 +: 8] = pam_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               win_ctrl <= WIN_RST;
    else if (we && win_sel)   win_ctrl <= wdata;
  end

  assign decode_touch = we && ((|pam_sel) || win_sel);

  always_comb begin
    rdata = 8'h00;
    if (size_sel) rdata = size_q;
    if (win_sel)  rdata = win_ctrl;
    for (int k = 0; k < PAM_BYTES; k++) begin
      if (pam_sel[k]) rdata = pam_q[k];
    end
  end

endmodule

// File: rtl/lrd_mode_map.sv
module lrd_mode_map #(
  parameter int PAM_BYTES = 7,
  localparam int SEG_NUM  = 1 + 2 * (PAM_BYTES - 1)
) (
  input  logic [PAM_BYTES*8-1:0] pam_flat,
  output logic [SEG_NUM*2-1:0]   seg_modes
);
  logic pam_spare_unused;
  assign pam_spare_unused = ^pam_flat;

  // Segment 0 is the top 64 KiB block, upper nibble of the first byte.
  assign seg_modes[1:0] = pam_flat[5:4];

  // Segment s>0 is the 16 KiB block i=s-1, packed two per byte.
  for (genvar s = 1; s < SEG_NUM; s++) begin : g_seg
    localparam int BYTE_IX = 1 + (s - 1) / 2;
    localparam int BIT_LO  = ((s - 1) % 2) * 4;
    assign seg_modes[s*2 +: 2] = pam_flat[BYTE_IX*8 + BIT_LO +: 2];
  end

endmodule

// File: rtl/lrd_addr_route.sv
module lrd_addr_route #(
  parameter int ADDR_W  = 20,
  parameter int SEG_NUM = 13,
  parameter int SEG_SH  = 14,
  localparam int IDX_W  = $clog2(SEG_NUM)
) (
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 acc_write,
  input  logic                 smm_active,
  input  logic [7:0]           win_ctrl,
  input  logic [SEG_NUM*2-1:0] seg_modes,
  output lrd_pkg::area_e       area,
  output logic [IDX_W-1:0]     seg_idx,
  output logic [1:0]           cur_mode,
  output logic                 sel_ram,
  output logic                 wr_block
);
  import lrd_pkg::*;

  localparam logic [ADDR_W-1:0] WIN_LO    = ADDR_W'(20'hA0000);
  localparam logic [ADDR_W-1:0] SHADOW_LO = ADDR_W'(20'hC0000);
  localparam logic [ADDR_W-1:0] TOP_LO    = ADDR_W'(20'hF0000);

  logic [ADDR_W-1:0] shadow_off;
  assign shadow_off = acc_addr - SHADOW_LO;

  always_comb begin
    if (acc_addr < WIN_LO)         area = AREA_LOW;
    else if (acc_addr < SHADOW_LO) area = AREA_WINDOW;
    else                           area = AREA_SHADOW;
  end

  always_comb begin
    seg_idx = '0;
    if (area == AREA_SHADOW && acc_addr < TOP_LO)
      seg_idx = IDX_W'((shadow_off >> SEG_SH) + 1'b1);
  end

  assign cur_mode = seg_modes[seg_idx*2 +: 2];

  always_comb begin
    sel_ram  = 1'b1;
    wr_block = 1'b0;
    case (area)
      AREA_WINDOW: sel_ram = window_open(win_ctrl, smm_active);
      AREA_SHADOW: begin
        sel_ram  = mode_hits_ram(cur_mode);
        wr_block = mode_drops_write(cur_mode, acc_write);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/legacy_region_decoder.sv
module legacy_region_decoder #(
  parameter int          ADDR_W    = 20,
  parameter int          CFG_AW    = 8,
  parameter int          MIB_W     = 16,
  parameter int          PAM_BYTES = 7,
  parameter logic [7:0]  PAM_BASE  = 8'h59,
  parameter logic [7:0]  WIN_OFF   = 8'h72,
  parameter logic [7:0]  SIZE_OFF  = 8'h57,
  parameter logic [7:0]  WIN_RST   = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [MIB_W-1:0]  ram_size_mib,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic              smm_active,
  output logic              sel_ram,
  output logic              wr_block
);
  localparam int SEG_NUM = 1 + 2 * (PAM_BYTES - 1);
  localparam int IDX_W   = $clog2(SEG_NUM);

  logic [PAM_BYTES*8-1:0] pam_flat;
  logic [7:0]             win_ctrl;
  logic                   decode_touch;
  logic [SEG_NUM*2-1:0]   seg_modes;
  lrd_pkg::area_e         area;
  logic [IDX_W-1:0]       seg_idx;
  logic [1:0]             cur_mode;

  lrd_cfg_regs #(
    .CFG_AW(CFG_AW), .PAM_BYTES(PAM_BYTES), .PAM_BASE(PAM_BASE),
    .WIN_OFF(WIN_OFF), .SIZE_OFF(SIZE_OFF), .WIN_RST(WIN_RST), .MIB_W(MIB_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ram_size_mib(ram_size_mib),
    .pam_flat(pam_flat), .win_ctrl(win_ctrl), .decode_touch(decode_touch)
  );

  lrd_mode_map #(.PAM_BYTES(PAM_BYTES)) u_map (
    .pam_flat(pam_flat), .seg_modes(seg_modes)
  );

  lrd_addr_route #(.ADDR_W(ADDR_W), .SEG_NUM(SEG_NUM)) u_route (
    .acc_addr(acc_addr), .acc_write(acc_write), .smm_active(smm_active),
    .win_ctrl(win_ctrl), .seg_modes(seg_modes), .area(area),
    .seg_idx(seg_idx), .cur_mode(cur_mode), .sel_ram(sel_ram),
    .wr_block(wr_block)
  );

endmodule

// File: rtl/lrd_checker.sv
module lrd_checker #(
  parameter int          ADDR_W  = 20,
  parameter int          CFG_AW  = 8,
  parameter logic [7:0]  WIN_OFF = 8'h72,
  parameter logic [7:0]  WIN_RST = 8'h02
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_write,
  input logic              smm_active,
  input logic              sel_ram,
  input logic              wr_block
);
  logic [7:0] ctrl_shadow;
  logic       in_low;
  logic       in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_shadow <= WIN_RST;
    else if (cfg_we && cfg_addr == CFG_AW'(WIN_OFF)) ctrl_shadow <= cfg_wdata;
  end

  assign in_low    = acc_addr < ADDR_W'(20'hA0000);
  assign in_window = !in_low && acc_addr < ADDR_W'(20'hC0000);

  // R2
  low_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_low |-> (sel_ram && !wr_block));

  // R6
  drop_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |-> (acc_write && sel_ram));

  // R6
  read_never_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_write |-> !wr_block);

  // R7
  window_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (sel_ram == ((smm_active && ctrl_shadow[3]) || ctrl_shadow[6])));

  // R7
  window_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> !wr_block);

endmodule

bind legacy_region_decoder lrd_checker #(
  .ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .WIN_OFF(WIN_OFF), .WIN_RST(WIN_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .acc_addr(acc_addr), .acc_write(acc_write),
  .smm_active(smm_active), .sel_ram(sel_ram), .wr_block(wr_block)
);

// File: tb/legacy_region_decoder_test.sv
module legacy_region_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [15:0] ram_size_mib = 16'd0;
  logic [19:0] acc_addr = 20'h0;
  logic        acc_write = 1'b0;
  logic        smm_active = 1'b0;
  logic        sel_ram;
  logic        wr_block;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] pam_b [7];

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_region_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ram_size_mib(ram_size_mib),
    .acc_addr(acc_addr), .acc_write(acc_write), .smm_active(smm_active),
    .sel_ram(sel_ram), .wr_block(wr_block)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    cfg_addr = a;
    #1;
    check(req, int'(cfg_rdata), int'(exp));
  endtask

  task automatic probe(input logic [19:0] a, input logic wr);
    acc_addr = a; acc_write = wr;
    #1;
  endtask

  // Expected mode of a shadow-area address, from the bench's byte copy.
  function automatic int exp_mode(input logic [19:0] a);
    int i;
    if (a >= 20'hF0000) return (int'(pam_b[0]) >> 4) & 3;
    i = (int'(a) - 'hC0000) / 'h4000;
    return (int'(pam_b[1 + i / 2]) >> ((i % 2) * 4)) & 3;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfg_read_check("R1 win ctrl reset", 8'h72, 8'h02);
    for (int k = 0; k < 7; k++) cfg_read_check("R1 mode byte reset", 8'(8'h59 + k), 8'h00);
    for (int s = 0; s < 13; s++) begin
      logic [19:0] a;
      a = (s == 0) ? 20'hF0000 : 20'(32'hC0000 + (s - 1) * 32'h4000);
      probe(a, 1'b0);
      check("R1 segment to PCI after reset", int'(sel_ram), 0);
    end

    // R3 R4 R5 R6 R10 sweep of mode patterns
    for (int t = 0; t < 8; t++) begin
      for (int k = 0; k < 7; k++) begin
        int lo_m, hi_m, junk;
        junk = (t * 37 + k * 11) & 'hCC;
        if (k == 0) begin
          hi_m = t % 4;
          lo_m = (t * 3) & 3;
          pam_b[k] = 8'((hi_m << 4) | lo_m | junk);
        end else begin
          lo_m = (t + (2 * k - 1) * 3) % 4;
          hi_m = (t + (2 * k) * 3) % 4;
          pam_b[k] = 8'(lo_m | (hi_m << 4) | junk);
        end
        cfg_write(8'(8'h59 + k), pam_b[k]);
      end
      for (int k = 0; k < 7; k++) cfg_read_check("R10 mode byte readback", 8'(8'h59 + k), pam_b[k]);
      for (int s = 0; s < 13; s++) begin
        logic [19:0] base, last;
        if (s == 0) begin base = 20'hF0000; last = 20'hFFFFF; end
        else begin
          base = 20'(32'hC0000 + (s - 1) * 32'h4000);
          last = base + 20'h3FFF;
        end
        for (int e = 0; e < 2; e++) begin
          for (int w = 0; w < 2; w++) begin
            int m;
            m = exp_mode(e == 0 ? base : last);
            probe(e == 0 ? base : last, w[0]);
            if (s == 0) check("R3 top segment routing", int'(sel_ram), int'(m == 1 || m == 3));
            else        check("R4 R5 segment routing", int'(sel_ram), int'(m == 1 || m == 3));
            check("R6 write drop", int'(wr_block), int'(w == 1 && m == 1));
          end
        end
      end
      smm_active = t[0];
      for (int w = 0; w < 2; w++) begin
        probe(20'h00000, w[0]);
        check("R2 low start", int'({sel_ram, wr_block}), 2);
        probe(20'h9FFFF, w[0]);
        check("R2 low end", int'({sel_ram, wr_block}), 2);
      end
    end

    // R7 window condition, every control and mode combination
    for (int c = 0; c < 8; c++) begin
      logic [7:0] ctrl;
      ctrl = 8'h02 | (c[0] ? 8'h08 : 8'h00) | (c[1] ? 8'h40 : 8'h00) | (c[2] ? 8'hA5 : 8'h00);
      cfg_write(8'h72, ctrl);
      cfg_read_check("R10 win ctrl readback", 8'h72, ctrl);
      for (int sm = 0; sm < 2; sm++) begin
        @(negedge clk);
        smm_active = sm[0];
        for (int w = 0; w < 2; w++) begin
          int exp_ram;
          exp_ram = int'((sm == 1 && ctrl[3]) || ctrl[6]);
          probe(20'hA0000, w[0]);
          check("R7 window start", int'(sel_ram), exp_ram);
          check("R7 window no drop", int'(wr_block), 0);
          probe(20'hBFFFF, w[0]);
          check("R7 window end", int'(sel_ram), exp_ram);
        end
      end
    end

    // R9 timing of a configuration write and of the mode input
    cfg_write(8'h59, 8'h00);
    @(negedge clk);
    acc_addr = 20'hF8000; acc_write = 1'b0;
    cfg_we = 1'b1; cfg_addr = 8'h59; cfg_wdata = 8'h30;
    #1;
    check("R9 before capture edge", int'(sel_ram), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    check("R9 after capture edge", int'(sel_ram), 1);
    cfg_write(8'h72, 8'h08);
    @(negedge clk);
    smm_active = 1'b0; acc_addr = 20'hB0000;
    #1;
    check("R9 window closed without mode", int'(sel_ram), 0);
    smm_active = 1'b1;
    #1;
    check("R9 mode input same cycle", int'(sel_ram), 1);

    // R8 size byte saturation and write ignore
    begin
      int sizes [9] = '{0, 7, 8, 1024, 2039, 2040, 2047, 2048, 65535};
      foreach (sizes[n]) begin
        int q;
        ram_size_mib = 16'(sizes[n]);
        q = sizes[n] / 8;
        if (q > 255) q = 255;
        cfg_read_check("R8 size units", 8'h57, 8'(q));
      end
      ram_size_mib = 16'd512;
      cfg_write(8'h57, 8'hAA);
      cfg_read_check("R8 size write ignored", 8'h57, 8'd64);
    end

    // R10 unrelated offsets read zero and keep no state
    begin
      logic [7:0] offs [5] = '{8'h00, 8'h58, 8'h60, 8'h71, 8'h73};
      foreach (offs[n]) begin
        cfg_write(offs[n], 8'hFF);
        cfg_read_check("R10 unmapped offset", offs[n], 8'h00);
      end
      cfg_read_check("R10 mode byte untouched", 8'h59, 8'h30);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule